// File: doc/BRIEF.md
# Pipeline Forwarding and Interlock Unit

This block manages operand bypassing and load-use hazards for a scalar, in-order pipeline with six stages: fetch, decode, register read, execute (ALU), memory and writeback. It works one stage early. It compares each live source register of the instruction in the register-read stage against the destinations of the two older instructions now in the ALU and memory stages. The chosen operand source is captured in a register, so the selection is ready when the instruction reaches the ALU stage. In that stage a small mux tree per operand picks one of four values: the register-file value, the ALU output latch, the memory-stage result latch, or the load-data latch.

A producer three instructions older is in writeback while the consumer reads registers. The register file around this block writes before it reads, so that value needs no bypass. An ALU result is never stalled on. A load followed at once by a consumer of the loaded register raises a single-cycle stall. The stall holds fetch, decode and register read, and a bubble is placed into the ALU stage. On the next cycle the load sits in the memory stage, and the consumer is steered to the load-data latch.

Top module: `fwd_interlock_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first capture edge, every operand select reads 0 (register file) and every operand output equals its register-file input.
- R2: A source that matches the destination of a non-load writing producer in the ALU stage gets select code 1 on the next cycle. Its operand then equals the ALU output latch input, and no stall is raised.
- R3: A source that matches only a non-load writing producer in the memory stage gets select code 2 on the next cycle. Its operand then equals the memory result latch input.
- R4: A source that matches only a load in the memory stage gets select code 3 on the next cycle. Its operand then equals the load-data latch input, and no stall is raised.
- R5: A live source that matches a writing load in the ALU stage raises the stall output in that same cycle, with no clock edge in between. On the next cycle every operand select is 0, because the bubble carries no forwarding.
- R6: A source with no match in the ALU or memory stage gets select code 0 and takes the register-file value. This includes a producer three instructions older, which is in writeback.
- R7: When the ALU-stage and memory-stage producers both match, the ALU-stage (younger) producer decides the result.
- R8: A producer is ignored unless both its valid bit and its write-enable bit are set. A source is ignored unless the register-read stage is valid and that source's use bit is set.
- R9: With register 0 hard-wired to zero (the default), a source index of 0 never matches any producer.
- R10: A load followed by an immediate consumer costs exactly one stall cycle, after which the consumer receives the loaded value (0x99 in the example). An add of 0x0123 and 0x0123 reaches a direct consumer as 0x0246 with no stall.
- R11: Each operand is decoded independently: one operand may forward while the other does not. The stall is raised if any operand has a load-use hazard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid_i | input | 1 | Register-read stage holds a valid instruction |
| rd_src_use_i | input | NUM_SRC | Per-source use bit of the register-read instruction |
| rd_src_idx_i | input | NUM_SRC x REG_W | Per-source register index in the register-read stage |
| alu_valid_i | input | 1 | ALU stage holds a valid instruction |
| alu_we_i | input | 1 | ALU-stage instruction writes a register |
| alu_is_load_i | input | 1 | ALU-stage instruction is a load |
| alu_dst_i | input | REG_W | ALU-stage destination register |
| mem_valid_i | input | 1 | Memory stage holds a valid instruction |
| mem_we_i | input | 1 | Memory-stage instruction writes a register |
| mem_is_load_i | input | 1 | Memory-stage instruction is a load |
| mem_dst_i | input | REG_W | Memory-stage destination register |
| alu_rf_opnd_i | input | NUM_SRC x DATA_W | Register-file operand values held for the ALU-stage instruction |
| byp_alu_q_i | input | DATA_W | ALU output latch (result of the instruction in the memory stage) |
| byp_mem_q_i | input | DATA_W | Memory-stage result latch (ALU result of the instruction in writeback) |
| byp_load_q_i | input | DATA_W | Load-data latch (data-cache output for the load in writeback) |
| alu_opnd_o | output | NUM_SRC x DATA_W | Selected operands at the ALU inputs |
| alu_src_sel_o | output | NUM_SRC x 2 | Registered operand source code: 0 file, 1 ALU latch, 2 memory latch, 3 load latch |
| stall_o | output | 1 | Load-use stall: hold fetch, decode and read, and place a bubble into the ALU stage |

## Verification
The assertions assume that the surrounding pipeline honours the stall. On the cycle after a stall, the ALU stage holds a bubble (valid low), and the load that caused the stall has moved on to the memory stage. Only under this assumption does the check that a stall never lasts two cycles hold. Producer fields are taken as meaningful only when their valid and write-enable bits are set. The sweeps keep within this assumption. After every applied pattern they drive one idle cycle in which all producer valids are low, and the directed load sequence moves the load from the ALU stage to the memory stage exactly as the pipeline would.

// File: rtl/fwd_pkg.sv
`timescale 1ns/1ps
package fwd_pkg;
  localparam int unsigned FWD_SRC_W = 2;

  // Operand source codes; the numeric values are visible on alu_src_sel_o.
  typedef enum logic [FWD_SRC_W-1:0] {
    SRC_RF         = 2'd0,
    SRC_ALU_LATCH  = 2'd1,
    SRC_MEM_LATCH  = 2'd2,
    SRC_LOAD_LATCH = 2'd3
  } fwd_src_e;
endpackage

// File: rtl/fwd_match.sv
`timescale 1ns/1ps
// One comparator: a source against one in-flight producer (R8, R9).
module fwd_match #(
  parameter int unsigned REG_W         = 5,
  parameter bit          ZERO_REG_HARD = 1'b1
) (
  input  logic [REG_W-1:0] src_idx_i,
  input  logic             src_live_i,
  input  logic             prod_valid_i,
  input  logic             prod_we_i,
  input  logic [REG_W-1:0] prod_dst_i,
  output logic             hit_o
);
  logic idx_eq;
  logic idx_ok;

  assign idx_eq = (src_idx_i == prod_dst_i);

  generate
    if (ZERO_REG_HARD) begin : g_zero_hard
      assign idx_ok = (src_idx_i != '0);
    end else begin : g_zero_soft
      assign idx_ok = 1'b1;
    end
  endgenerate

  assign hit_o = src_live_i & prod_valid_i & prod_we_i & idx_eq & idx_ok;
endmodule

// File: rtl/fwd_src_decode.sv
`timescale 1ns/1ps
// Per-operand source decode in the register-read stage.
// Younger producer (ALU stage) outranks older one (memory stage): R7.
module fwd_src_decode
  import fwd_pkg::*;
#(
  parameter int unsigned REG_W         = 5,
  parameter bit          ZERO_REG_HARD = 1'b1
) (
  input  logic [REG_W-1:0] src_idx_i,
  input  logic             src_live_i,
  input  logic             p1_valid_i,
  input  logic             p1_we_i,
  input  logic             p1_load_i,
  input  logic [REG_W-1:0] p1_dst_i,
  input  logic             p2_valid_i,
  input  logic             p2_we_i,
  input  logic             p2_load_i,
  input  logic [REG_W-1:0] p2_dst_i,
  output fwd_src_e         sel_o,
  output logic             hazard_o
);
  logic hit_p1;
  logic hit_p2;

  fwd_match #(.REG_W(REG_W), .ZERO_REG_HARD(ZERO_REG_HARD)) u_cmp_p1 (
    .src_idx_i    (src_idx_i),
    .src_live_i   (src_live_i),
    .prod_valid_i (p1_valid_i),
    .prod_we_i    (p1_we_i),
    .prod_dst_i   (p1_dst_i),
    .hit_o        (hit_p1)
  );

  fwd_match #(.REG_W(REG_W), .ZERO_REG_HARD(ZERO_REG_HARD)) u_cmp_p2 (
    .src_idx_i    (src_idx_i),
    .src_live_i   (src_live_i),
    .prod_valid_i (p2_valid_i),
    .prod_we_i    (p2_we_i),
    .prod_dst_i   (p2_dst_i),
    .hit_o        (hit_p2)
  );

  always_comb begin
    hazard_o = 1'b0;
    sel_o    = SRC_RF;                       // R6: no match, file value
    if (hit_p1 && p1_load_i) begin
      hazard_o = 1'b1;                       // R5: load data not yet back
    end else if (hit_p1) begin
      sel_o = SRC_ALU_LATCH;                 // R2
    end else if (hit_p2 && p2_load_i) begin
      sel_o = SRC_LOAD_LATCH;                // R4
    end else if (hit_p2) begin
      sel_o = SRC_MEM_LATCH;                 // R3
    end
  end
endmodule

// File: rtl/fwd_operand_mux.sv
`timescale 1ns/1ps
// Two-level 2:1 mux tree in front of one ALU input.
module fwd_operand_mux
  import fwd_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  fwd_src_e          sel_i,
  input  logic [DATA_W-1:0] rf_i,
  input  logic [DATA_W-1:0] alu_q_i,
  input  logic [DATA_W-1:0] mem_q_i,
  input  logic [DATA_W-1:0] load_q_i,
  output logic [DATA_W-1:0] opnd_o
);
  logic [FWD_SRC_W-1:0] sel_bits;
  logic [DATA_W-1:0]    near_v;
  logic [DATA_W-1:0]    far_v;

  assign sel_bits = sel_i;
  assign near_v   = sel_bits[0] ? alu_q_i  : rf_i;
  assign far_v    = sel_bits[0] ? load_q_i : mem_q_i;
  assign opnd_o   = sel_bits[1] ? far_v    : near_v;
endmodule

// File: rtl/fwd_interlock_unit.sv
`timescale 1ns/1ps
module fwd_interlock_unit
  import fwd_pkg::*;
#(
  parameter int unsigned NUM_SRC       = 2,
  parameter int unsigned REG_W         = 5,
  parameter int unsigned DATA_W        = 32,
  parameter bit          ZERO_REG_HARD = 1'b1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               rd_valid_i,
  input  logic [NUM_SRC-1:0]                 rd_src_use_i,
  input  logic [NUM_SRC-1:0][REG_W-1:0]      rd_src_idx_i,
  input  logic                               alu_valid_i,
  input  logic                               alu_we_i,
  input  logic                               alu_is_load_i,
  input  logic [REG_W-1:0]                   alu_dst_i,
  input  logic                               mem_valid_i,
  input  logic                               mem_we_i,
  input  logic                               mem_is_load_i,
  input  logic [REG_W-1:0]                   mem_dst_i,
  input  logic [NUM_SRC-1:0][DATA_W-1:0]     alu_rf_opnd_i,
  input  logic [DATA_W-1:0]                  byp_alu_q_i,
  input  logic [DATA_W-1:0]                  byp_mem_q_i,
  input  logic [DATA_W-1:0]                  byp_load_q_i,
  output logic [NUM_SRC-1:0][DATA_W-1:0]     alu_opnd_o,
  output logic [NUM_SRC-1:0][FWD_SRC_W-1:0]  alu_src_sel_o,
  output logic                               stall_o
);
  logic [NUM_SRC-1:0] src_live;
  logic [NUM_SRC-1:0] hazard;
  fwd_src_e           sel_dec [NUM_SRC];
  fwd_src_e           sel_d   [NUM_SRC];
  fwd_src_e           sel_q   [NUM_SRC];

  // Register-read stage: one decoder per source operand (R11).
  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_dec
      assign src_live[g] = rd_valid_i & rd_src_use_i[g];   // R8
      fwd_src_decode #(.REG_W(REG_W), .ZERO_REG_HARD(ZERO_REG_HARD)) u_dec (
        .src_idx_i  (rd_src_idx_i[g]),
        .src_live_i (src_live[g]),
        .p1_valid_i (alu_valid_i),
        .p1_we_i    (alu_we_i),
        .p1_load_i  (alu_is_load_i),
        .p1_dst_i   (alu_dst_i),
        .p2_valid_i (mem_valid_i),
        .p2_we_i    (mem_we_i),
        .p2_load_i  (mem_is_load_i),
        .p2_dst_i   (mem_dst_i),
        .sel_o      (sel_dec[g]),
        .hazard_o   (hazard[g])
      );
    end
  endgenerate

  // Combinational load-use interlock (R5, R11).
  assign stall_o = |hazard;

  // Next-state: a stalled cycle hands a bubble to the ALU stage (R5).
  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      sel_d[i] = stall_o ? SRC_RF : sel_dec[i];
    end
  end

  // Select register between register-read and ALU stages (R1).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SRC; i++) sel_q[i] <= SRC_RF;
    end else begin
      for (int i = 0; i < NUM_SRC; i++) sel_q[i] <= sel_d[i];
    end
  end

  // ALU stage: operand muxes.
  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_mux
      assign alu_src_sel_o[g] = sel_q[g];
      fwd_operand_mux #(.DATA_W(DATA_W)) u_mux (
        .sel_i    (sel_q[g]),
        .rf_i     (alu_rf_opnd_i[g]),
        .alu_q_i  (byp_alu_q_i),
        .mem_q_i  (byp_mem_q_i),
        .load_q_i (byp_load_q_i),
        .opnd_o   (alu_opnd_o[g])
      );
    end
  endgenerate
endmodule

// File: rtl/fwd_interlock_unit_chk.sv
`timescale 1ns/1ps
module fwd_interlock_unit_chk #(
  parameter int unsigned NUM_SRC       = 2,
  parameter int unsigned REG_W         = 5,
  parameter int unsigned DATA_W        = 32,
  parameter bit          ZERO_REG_HARD = 1'b1
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           rd_valid_i,
  input logic [NUM_SRC-1:0]             rd_src_use_i,
  input logic [NUM_SRC-1:0][REG_W-1:0]  rd_src_idx_i,
  input logic                           alu_valid_i,
  input logic                           alu_we_i,
  input logic                           alu_is_load_i,
  input logic [REG_W-1:0]               alu_dst_i,
  input logic [NUM_SRC-1:0][DATA_W-1:0] alu_rf_opnd_i,
  input logic [DATA_W-1:0]              byp_load_q_i,
  input logic [NUM_SRC-1:0][DATA_W-1:0] alu_opnd_o,
  input logic [NUM_SRC-1:0][1:0]        alu_src_sel_o,
  input logic                           stall_o
);
  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_op
      AST_LOAD_USE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_i && rd_src_use_i[g] && alu_valid_i && alu_we_i && alu_is_load_i &&
         (alu_dst_i == rd_src_idx_i[g]) && (rd_src_idx_i[g] != '0)) |-> stall_o); // R5

      AST_YOUNGEST_ALU_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_i && rd_src_use_i[g] && alu_valid_i && alu_we_i && !alu_is_load_i &&
         (alu_dst_i == rd_src_idx_i[g]) && (rd_src_idx_i[g] != '0) && !stall_o)
        |=> (alu_src_sel_o[g] == 2'd1)); // R7

      AST_IDLE_SOURCE_FILE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_valid_i || !rd_src_use_i[g]) |=> (alu_src_sel_o[g] == 2'd0)); // R8

      AST_LOAD_LATCH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_src_sel_o[g] == 2'd3) |-> (alu_opnd_o[g] == byp_load_q_i)); // R4

      AST_FILE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_src_sel_o[g] == 2'd0) |-> (alu_opnd_o[g] == alu_rf_opnd_i[g])); // R6

      if (ZERO_REG_HARD) begin : g_zero
        AST_ZERO_NEVER_FWD: assert property (@(posedge clk) disable iff (!rst_n)
          (rd_src_idx_i[g] == '0) |=> (alu_src_sel_o[g] == 2'd0)); // R9
      end
    end
  endgenerate

  AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> (alu_src_sel_o == '0)); // R5

  AST_STALL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> (alu_valid_i && alu_we_i && alu_is_load_i)); // R5

  AST_SINGLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> !stall_o); // R10
endmodule

bind fwd_interlock_unit fwd_interlock_unit_chk #(
  .NUM_SRC(NUM_SRC), .REG_W(REG_W), .DATA_W(DATA_W), .ZERO_REG_HARD(ZERO_REG_HARD)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rd_valid_i    (rd_valid_i),
  .rd_src_use_i  (rd_src_use_i),
  .rd_src_idx_i  (rd_src_idx_i),
  .alu_valid_i   (alu_valid_i),
  .alu_we_i      (alu_we_i),
  .alu_is_load_i (alu_is_load_i),
  .alu_dst_i     (alu_dst_i),
  .alu_rf_opnd_i (alu_rf_opnd_i),
  .byp_load_q_i  (byp_load_q_i),
  .alu_opnd_o    (alu_opnd_o),
  .alu_src_sel_o (alu_src_sel_o),
  .stall_o       (stall_o)
);

// File: tb/fwd_interlock_unit_tb_top.sv
`timescale 1ns/1ps
module fwd_interlock_unit_tb_top;
  localparam int unsigned NS = 2;
  localparam int unsigned RW = 2;
  localparam int unsigned DW = 16;

  localparam logic [DW-1:0] RF0 = 16'h1110;
  localparam logic [DW-1:0] RF1 = 16'h2220;
  localparam logic [DW-1:0] VA  = 16'hA0A0;
  localparam logic [DW-1:0] VM  = 16'hB0B0;
  localparam logic [DW-1:0] VL  = 16'hC0C0;

  logic                   clk = 1'b0;
  logic                   rst_n;
  logic                   rd_valid_i;
  logic [NS-1:0]          rd_src_use_i;
  logic [NS-1:0][RW-1:0]  rd_src_idx_i;
  logic                   alu_valid_i, alu_we_i, alu_is_load_i;
  logic [RW-1:0]          alu_dst_i;
  logic                   mem_valid_i, mem_we_i, mem_is_load_i;
  logic [RW-1:0]          mem_dst_i;
  logic [NS-1:0][DW-1:0]  alu_rf_opnd_i;
  logic [DW-1:0]          byp_alu_q_i, byp_mem_q_i, byp_load_q_i;
  logic [NS-1:0][DW-1:0]  alu_opnd_o;
  logic [NS-1:0][1:0]     alu_src_sel_o;
  logic                   stall_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  fwd_interlock_unit #(.NUM_SRC(NS), .REG_W(RW), .DATA_W(DW), .ZERO_REG_HARD(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd_valid_i(rd_valid_i), .rd_src_use_i(rd_src_use_i), .rd_src_idx_i(rd_src_idx_i),
    .alu_valid_i(alu_valid_i), .alu_we_i(alu_we_i), .alu_is_load_i(alu_is_load_i), .alu_dst_i(alu_dst_i),
    .mem_valid_i(mem_valid_i), .mem_we_i(mem_we_i), .mem_is_load_i(mem_is_load_i), .mem_dst_i(mem_dst_i),
    .alu_rf_opnd_i(alu_rf_opnd_i), .byp_alu_q_i(byp_alu_q_i), .byp_mem_q_i(byp_mem_q_i),
    .byp_load_q_i(byp_load_q_i), .alu_opnd_o(alu_opnd_o), .alu_src_sel_o(alu_src_sel_o),
    .stall_o(stall_o)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp_v);
    end
  endtask

  // Reference: {hazard, code} for one source, taken from the requirement text.
  function automatic logic [2:0] ref_sel(input logic rv, input logic use_b, input logic [RW-1:0] rs,
      input logic av, input logic awe, input logic ald, input logic [RW-1:0] adst,
      input logic mv, input logic mwe, input logic mld, input logic [RW-1:0] mdst);
    logic live, ah, mh;
    live = rv && use_b && (rs != 0);
    ah   = live && av && awe && (adst == rs);
    mh   = live && mv && mwe && (mdst == rs);
    if (ah) return ald ? 3'b100 : 3'b001;
    if (mh) return mld ? 3'b011 : 3'b010;
    return 3'b000;
  endfunction

  function automatic logic [DW-1:0] ref_data(input logic [1:0] code, input int g);
    case (code)
      2'd1:    return VA;
      2'd2:    return VM;
      2'd3:    return VL;
      default: return (g == 0) ? RF0 : RF1;
    endcase
  endfunction

  task automatic quiet();
    rd_valid_i = 1'b0; rd_src_use_i = '0; rd_src_idx_i = '0;
    alu_valid_i = 1'b0; alu_we_i = 1'b0; alu_is_load_i = 1'b0; alu_dst_i = '0;
    mem_valid_i = 1'b0; mem_we_i = 1'b0; mem_is_load_i = 1'b0; mem_dst_i = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    quiet();
    alu_rf_opnd_i[0] = RF0; alu_rf_opnd_i[1] = RF1;
    byp_alu_q_i = VA; byp_mem_q_i = VM; byp_load_q_i = VL;

    // R1: during reset, a live ALU-stage match must not reach the select register.
    @(negedge clk);
    rd_valid_i = 1'b1; rd_src_use_i = 2'b11; rd_src_idx_i[0] = 2'd1; rd_src_idx_i[1] = 2'd1;
    alu_valid_i = 1'b1; alu_we_i = 1'b1; alu_dst_i = 2'd1;
    repeat (3) @(negedge clk);
    chk("R1", "sel0 in reset", alu_src_sel_o[0], 0);
    chk("R1", "sel1 in reset", alu_src_sel_o[1], 0);
    chk("R1", "opnd0 in reset", alu_opnd_o[0], RF0);
    chk("R1", "opnd1 in reset", alu_opnd_o[1], RF1);
    quiet();
    rst_n = 1'b1;
    #1;
    chk("R1", "stall after reset", stall_o, 0);
    chk("R1", "sel0 after release", alu_src_sel_o[0], 0);

    // Near-exhaustive sweep of one operand against both producers.
    for (int g = 0; g < 2; g++) begin
      for (int v = 0; v < 16384; v++) begin
        logic [13:0] b;
        logic [2:0]  e;
        string       tag;
        b = v[13:0];
        @(negedge clk);
        alu_valid_i = b[0]; alu_we_i = b[1]; alu_is_load_i = b[2]; alu_dst_i = b[4:3];
        mem_valid_i = b[5]; mem_we_i = b[6]; mem_is_load_i = b[7]; mem_dst_i = b[9:8];
        rd_src_idx_i[0] = b[11:10]; rd_src_idx_i[1] = b[11:10];
        rd_src_use_i = '0; rd_src_use_i[g] = b[12];
        rd_valid_i = b[13];
        e = ref_sel(b[13], b[12], b[11:10], b[0], b[1], b[2], b[4:3], b[5], b[6], b[7], b[9:8]);
        if (!(b[13] && b[12]))                                          tag = "R8";
        else if (b[11:10] == 0)                                         tag = "R9";
        else if (e[2])                                                  tag = "R5";
        else if (e[1:0] == 2'd1 && b[5] && b[6] && b[9:8] == b[11:10]) tag = "R7";
        else if (e[1:0] == 2'd1)                                        tag = "R2";
        else if (e[1:0] == 2'd2)                                        tag = "R3";
        else if (e[1:0] == 2'd3)                                        tag = "R4";
        else                                                            tag = "R6";
        #1;
        chk(tag, "stall", stall_o, e[2]);
        @(negedge clk);
        chk(tag, "sel", alu_src_sel_o[g], e[1:0]);
        chk(tag, "opnd", alu_opnd_o[g], ref_data(e[1:0], g));
        chk("R11", "other sel", alu_src_sel_o[1-g], 0);
        quiet();
      end
    end

    // R11: two operands on different paths at once.
    @(negedge clk);
    rd_valid_i = 1'b1; rd_src_use_i = 2'b11; rd_src_idx_i[0] = 2'd1; rd_src_idx_i[1] = 2'd2;
    alu_valid_i = 1'b1; alu_we_i = 1'b1; alu_dst_i = 2'd1;
    mem_valid_i = 1'b1; mem_we_i = 1'b1; mem_is_load_i = 1'b1; mem_dst_i = 2'd2;
    #1; chk("R11", "mixed stall", stall_o, 0);
    @(negedge clk);
    chk("R11", "mixed sel0", alu_src_sel_o[0], 1);
    chk("R11", "mixed sel1", alu_src_sel_o[1], 3);
    chk("R11", "mixed opnd1", alu_opnd_o[1], VL);
    quiet();

    // R11: a hazard on operand 1 alone stalls, and both selects become file.
    @(negedge clk);
    rd_valid_i = 1'b1; rd_src_use_i = 2'b11; rd_src_idx_i[0] = 2'd2; rd_src_idx_i[1] = 2'd3;
    alu_valid_i = 1'b1; alu_we_i = 1'b1; alu_is_load_i = 1'b1; alu_dst_i = 2'd3;
    mem_valid_i = 1'b1; mem_we_i = 1'b1; mem_dst_i = 2'd2;
    #1; chk("R11", "one-sided stall", stall_o, 1);
    @(negedge clk);
    chk("R11", "bubble sel0", alu_src_sel_o[0], 0);
    chk("R11", "bubble sel1", alu_src_sel_o[1], 0);
    quiet();

    // R10: add 0x0123 + 0x0123 into R1, consumer follows directly.
    @(negedge clk);
    rd_valid_i = 1'b1; rd_src_use_i = 2'b11; rd_src_idx_i[0] = 2'd1; rd_src_idx_i[1] = 2'd1;
    alu_valid_i = 1'b1; alu_we_i = 1'b1; alu_dst_i = 2'd1;
    #1; chk("R10", "add stall", stall_o, 0);
    @(negedge clk);
    quiet();
    byp_alu_q_i = 16'h0123 + 16'h0123;
    #1;
    chk("R10", "add opnd0", alu_opnd_o[0], 16'h0246);
    chk("R10", "add opnd1", alu_opnd_o[1], 16'h0246);

    // R10: load R3 from 0x80+0x04 (returns 0x99), consumer follows directly.
    begin
      int stalls;
      logic [7:0] addr;
      stalls = 0;
      addr = 8'h80 + 8'h04;
      @(negedge clk);
      rd_valid_i = 1'b1; rd_src_use_i = 2'b01; rd_src_idx_i[0] = 2'd3;
      alu_valid_i = 1'b1; alu_we_i = 1'b1; alu_is_load_i = 1'b1; alu_dst_i = 2'd3;
      #1; if (stall_o) stalls++;
      @(negedge clk);
      // pipeline response: bubble in ALU stage, load now in memory stage
      alu_valid_i = 1'b0; alu_we_i = 1'b0; alu_is_load_i = 1'b0;
      mem_valid_i = 1'b1; mem_we_i = 1'b1; mem_is_load_i = 1'b1; mem_dst_i = 2'd3;
      #1; if (stall_o) stalls++;
      @(negedge clk);
      quiet();
      byp_load_q_i = (addr == 8'h84) ? 16'h0099 : 16'h0000;
      #1;
      chk("R10", "load stall cycles", stalls, 1);
      chk("R10", "load sel", alu_src_sel_o[0], 3);
      chk("R10", "load opnd", alu_opnd_o[0], 16'h0099);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule